// File: doc/BRIEF.md
# Paged GPIO Register Front End

This block sits between a byte-wide register bus and 48 digital lines organised as six 8-bit ports. One bus access per cycle selects a register by a small offset. The six lowest offsets hold the port registers. Writing a port register sets that port's pull-down controls, where a 1 pulls the pad low and a 0 releases it. Reading a port register returns the synchronised pin levels. A line is used as an input by leaving its pull bit at 0 and relying on an external pull-up.

The next two offsets are a summary of pending interrupts for the three interrupt-capable ports and a control byte. In the control byte, the two top bits select a register page and the six low bits lock the port registers against writes. The three highest offsets have no storage in this block. According to the selected page, they pass through to the polarity, enable or identification bytes of a companion interrupt unit, addressed by port. When page 0 is selected, those three offsets are inert.

Read data is registered and appears on the cycle after the read strobe. It holds until the next read. Widths, counts and the depth of the pin synchroniser are parameters.

Top module: `pgio_regfront`

## Requirements
- R1: After reset, every pad pull output is 0, the page field is 0 and all lock bits are 0, so the control byte at offset 7 reads 0x00.
- R2: A write to offset p (0 to 5) whose port is unlocked loads the 8 pull bits of port p. Line n is driven by pad_pull[n], which belongs to port n/8 and bit n%8. A value of 1 pulls the pad low and 0 releases it.
- R3: A read of offset p (0 to 5) returns pin_level for port p as seen through a synchroniser of SYNC_STAGES flops. The value appears on bus_rdata one cycle after the read strobe.
- R4: Offset 7 is the control byte. Bits 7:6 hold the page (1 polarity, 2 enable, 3 identification) and bits 5:0 lock ports 5..0. It reads back exactly as written.
- R5: While the lock bit of port p is 1, writes to offset p leave its pull bits unchanged, and reads of offset p still return the pin levels.
- R6: A read of offset 6 returns irq_pend in bits 2:0 and 0 in bits 7:3, using the value present at the clock edge that captures the read.
- R7: With a nonzero page, a write to offset 8+k (k = 0 to 2) raises iu_wr in that same cycle, with iu_kind equal to the page, iu_port equal to k and iu_wdata equal to the written byte.
- R8: With a nonzero page, a read of offset 8+k raises iu_rd in that cycle with the same kind and port, and returns iu_rdata.
- R9: With page 0, offsets 8 to 10 read 0x00 and raise neither iu_wr nor iu_rd.
- R10: Offsets 11 to 15 read 0x00, and writes to them change no pull bit and no control bit.
- R11: bus_rdata keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pin_level | input | 48 | Live pad levels |
| pad_pull | output | 48 | Pull-low controls, 1 pulls the pad low |
| irq_pend | input | 3 | Pending flags of the interrupt-capable ports |
| iu_wr | output | 1 | Write pulse to the interrupt unit |
| iu_rd | output | 1 | Read pulse to the interrupt unit |
| iu_kind | output | 2 | Page selecting polarity, enable or ID |
| iu_port | output | 2 | Interrupt-capable port index |
| iu_wdata | output | 8 | Byte written to the interrupt unit |
| iu_rdata | input | 8 | Byte returned by the interrupt unit |

## Verification
Two functions can fall in the same cycle. The first is an irq_pend change landing on the edge that captures a summary read. The bench drives the new pending value in the read cycle itself and expects that new value back. The second is a lock taking effect right before a port write. The bench sets a lock and then writes the locked port, and judges the pad outputs together with a read of the live pins through the open-drain loopback.

// File: rtl/pgio_pkg.sv
package pgio_pkg;
   typedef enum logic [1:0] {
      PG_OFF = 2'd0,
      PG_POL = 2'd1,
      PG_ENA = 2'd2,
      PG_ID  = 2'd3
   } page_e;

   typedef enum logic [2:0] {
      RG_PORT,
      RG_PEND,
      RG_CTL,
      RG_PAGED,
      RG_VOID
   } region_e;
endpackage

// File: rtl/pgio_decode.sv
module pgio_decode
   import pgio_pkg::*;
#(
   parameter int N_PORTS     = 6,
   parameter int N_IRQ_PORTS = 3,
   parameter int ADDR_W      = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [ADDR_W-1:0] sub_idx
);
   localparam int PEND_OFS   = N_PORTS;
   localparam int CTL_OFS    = N_PORTS + 1;
   localparam int PAGED_BASE = N_PORTS + 2;
   localparam int LAST_OFS   = PAGED_BASE + N_IRQ_PORTS - 1;

   if (LAST_OFS >= (1 << ADDR_W)) begin : g_bad_window
      $error("pgio_decode: address window does not fit ADDR_W");
   end

   always_comb begin
      region  = RG_VOID;
      sub_idx = '0;
      if (int'(addr) < N_PORTS) begin
         region  = RG_PORT;
         sub_idx = addr;
      end else if (int'(addr) == PEND_OFS) begin
         region = RG_PEND;
      end else if (int'(addr) == CTL_OFS) begin
         region = RG_CTL;
      end else if (int'(addr) <= LAST_OFS) begin
         region  = RG_PAGED;
         sub_idx = addr - ADDR_W'(PAGED_BASE);
      end
   end
endmodule

// File: rtl/pgio_pin_sync.sv
module pgio_pin_sync #(
   parameter int WIDTH  = 48,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 0) begin : g_bad_stages
      $error("pgio_pin_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign dout = din;
   end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign dout = chain[STAGES-1];
   end
endmodule

// File: rtl/pgio_port_bank.sv
module pgio_port_bank #(
   parameter int N_PORTS = 6,
   parameter int PORT_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PORTS-1:0]          wr_hit,
   input  logic [N_PORTS-1:0]          lock,
   input  logic [PORT_W-1:0]           wdata,
   output logic [N_PORTS*PORT_W-1:0]   pull
);
   for (genvar g = 0; g < N_PORTS; g++) begin : g_port
      logic [PORT_W-1:0] q;

      always_ff @(posedge clk) begin
         if (!rst_n)                      q <= '0;
         else if (wr_hit[g] && !lock[g])  q <= wdata;
      end

      assign pull[g*PORT_W +: PORT_W] = q;

      AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         lock[g] |=> $stable(q)); // R5
      AST_UNLOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit[g] && !lock[g]) |=> (q == $past(wdata))); // R2
   end
endmodule

// File: rtl/pgio_regfront.sv
module pgio_regfront
   import pgio_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int N_PORTS     = 6,
   parameter int N_IRQ_PORTS = 3,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int N_LINES    = N_PORTS * PORT_W,
   localparam int PIDX_W     = (N_IRQ_PORTS > 1) ? $clog2(N_IRQ_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [PORT_W-1:0]    bus_wdata,
   output logic [PORT_W-1:0]    bus_rdata,
   input  logic [N_LINES-1:0]   pin_level,
   output logic [N_LINES-1:0]   pad_pull,
   input  logic [N_IRQ_PORTS-1:0] irq_pend,
   output logic                 iu_wr,
   output logic                 iu_rd,
   output logic [1:0]           iu_kind,
   output logic [PIDX_W-1:0]    iu_port,
   output logic [PORT_W-1:0]    iu_wdata,
   input  logic [PORT_W-1:0]    iu_rdata
);
   localparam int PSEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

   if (PORT_W < N_PORTS + 2) begin : g_bad_ctl
      $error("pgio_regfront: control byte cannot hold page and lock fields");
   end
   if (N_IRQ_PORTS > N_PORTS || N_IRQ_PORTS > PORT_W) begin : g_bad_irq
      $error("pgio_regfront: too many interrupt-capable ports");
   end
   if (PIDX_W > ADDR_W || PSEL_W > ADDR_W) begin : g_bad_idx
      $error("pgio_regfront: index wider than address");
   end

   region_e           region;
   logic [ADDR_W-1:0] sub_idx;

   pgio_decode #(
      .N_PORTS(N_PORTS), .N_IRQ_PORTS(N_IRQ_PORTS), .ADDR_W(ADDR_W)
   ) u_dec (
      .addr(bus_addr), .region(region), .sub_idx(sub_idx)
   );

   logic wr_any, rd_any;
   assign wr_any = bus_sel &  bus_we;
   assign rd_any = bus_sel & ~bus_we;

   // control byte: page in the top two bits, locks in the low bits
   page_e              page_q;
   logic [N_PORTS-1:0] lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= PG_OFF;
         lock_q <= '0;
      end else if (wr_any && region == RG_CTL) begin
         page_q <= page_e'(bus_wdata[PORT_W-1 -: 2]);
         lock_q <= bus_wdata[N_PORTS-1:0];
      end
   end

   logic [PORT_W-1:0] ctl_rd;
   always_comb begin
      ctl_rd                 = '0;
      ctl_rd[PORT_W-1 -: 2]  = page_q;
      ctl_rd[N_PORTS-1:0]    = lock_q;
   end

   // port output bank
   logic [N_PORTS-1:0] wr_hit;
   always_comb begin
      for (int g = 0; g < N_PORTS; g++)
         wr_hit[g] = wr_any && (region == RG_PORT) && (int'(sub_idx) == g);
   end

   pgio_port_bank #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .lock(lock_q),
      .wdata(bus_wdata), .pull(pad_pull)
   );

   // pin synchroniser and byte view
   logic [N_LINES-1:0] pin_sync;
   pgio_pin_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_level), .dout(pin_sync)
   );

   logic [PORT_W-1:0] pin_byte [N_PORTS];
   for (genvar g = 0; g < N_PORTS; g++) begin : g_byte
      assign pin_byte[g] = pin_sync[g*PORT_W +: PORT_W];
   end

   // paged pass-through to the interrupt unit
   logic paged_live;
   assign paged_live = (region == RG_PAGED) && (page_q != PG_OFF);
   assign iu_wr    = wr_any & paged_live;
   assign iu_rd    = rd_any & paged_live;
   assign iu_kind  = page_q;
   assign iu_port  = sub_idx[PIDX_W-1:0];
   assign iu_wdata = bus_wdata;

   // read mux and registered read data
   logic [PORT_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (region)
         RG_PORT:  rd_mux = pin_byte[sub_idx[PSEL_W-1:0]];
         RG_PEND:  rd_mux[N_IRQ_PORTS-1:0] = irq_pend;
         RG_CTL:   rd_mux = ctl_rd;
         RG_PAGED: rd_mux = paged_live ? iu_rdata : '0;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_any) bus_rdata <= rd_mux;
   end

   AST_PAGE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (page_q == PG_OFF) |-> (!iu_wr && !iu_rd)); // R9
   AST_IU_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iu_wr, iu_rd})); // R7
   AST_PEND_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && region == RG_PEND) |=> (bus_rdata[PORT_W-1:N_IRQ_PORTS] == '0)); // R6
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> $stable(bus_rdata)); // R11
   AST_VOID_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && region == RG_VOID) |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/pgio_regfront_test.sv
module pgio_regfront_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_level, pad_pull;
   logic [47:0] ext_level = '1;
   logic [2:0]  irq_pend = '0;
   logic        iu_wr, iu_rd;
   logic [1:0]  iu_kind, iu_port;
   logic [7:0]  iu_wdata, iu_rdata;

   always #10 clk = ~clk; // 50 MHz

   // open-drain pads with external pull-ups
   assign pin_level = ext_level & ~pad_pull;
   // interrupt unit model: byte encodes kind and port
   assign iu_rdata  = {4'hC, iu_kind, iu_port};

   pgio_regfront uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_level(pin_level), .pad_pull(pad_pull), .irq_pend(irq_pend),
      .iu_wr(iu_wr), .iu_rd(iu_rd), .iu_kind(iu_kind), .iu_port(iu_port),
      .iu_wdata(iu_wdata), .iu_rdata(iu_rdata)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] d; string tag; } exp_t;
   exp_t sb_q[$];

   logic cap_wr, cap_rd;
   logic [1:0] cap_kind, cap_port;
   logic [7:0] cap_wdata;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic capture_iu();
      #1;
      cap_wr = iu_wr; cap_rd = iu_rd; cap_kind = iu_kind;
      cap_port = iu_port; cap_wdata = iu_wdata;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      capture_iu();
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      e.d = exp; e.tag = tag;
      sb_q.push_back(e);
      capture_iu();
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compares each registered read result against the scoreboard
   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= bus_sel && !bus_we && rst_n;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", 64'(bus_rdata), 64'h0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(bus_rdata === e.d, e.tag, 64'(bus_rdata), 64'(e.d));
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state
      check(pad_pull == '0, "R1 pulls after reset", 64'(pad_pull), 64'h0);
      bus_read(4'd7, 8'h00, "R1 control byte after reset");

      // R2 port writes
      bus_write(4'd0, 8'hA5);
      bus_write(4'd5, 8'h3C);
      check(pad_pull == 48'h3C00_0000_00A5, "R2 pull bits port0/port5", 64'(pad_pull), 64'h3C0000_0000A5);

      // R3 pin reads through synchroniser and open-drain loopback
      settle(4);
      bus_read(4'd0, 8'h5A, "R3 port0 pins with pulls");
      bus_read(4'd3, 8'hFF, "R3 port3 released pins");
      ext_level[31:24] = 8'h81;
      settle(4);
      bus_read(4'd3, 8'h81, "R3 port3 external pattern");
      // R11 hold
      settle(3);
      check(bus_rdata == 8'h81, "R11 rdata holds while idle", 64'(bus_rdata), 64'h81);

      // R4 / R5 lock port0, then write it back-to-back
      bus_write(4'd7, 8'h81);
      bus_read(4'd7, 8'h81, "R4 control readback");
      bus_write(4'd0, 8'hFF);
      check(pad_pull[7:0] == 8'hA5, "R5 locked port keeps pulls", 64'(pad_pull[7:0]), 64'hA5);
      settle(4);
      bus_read(4'd0, 8'h5A, "R5 locked port still readable");
      bus_write(4'd1, 8'h0F);
      check(pad_pull[15:8] == 8'h0F, "R2 unlocked port1 write", 64'(pad_pull[15:8]), 64'h0F);

      // R6 pending summary, incl. change in the read cycle
      irq_pend = 3'b101;
      bus_read(4'd6, 8'h05, "R6 pending summary");
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'd6; irq_pend = 3'b010;
      begin exp_t e; e.d = 8'h02; e.tag = "R6 pending changed in read cycle"; sb_q.push_back(e); end
      @(negedge clk);
      bus_sel = 1'b0;

      // R7 / R8 paged accesses
      bus_write(4'd7, 8'h80);
      bus_write(4'd9, 8'h77);
      check(cap_wr && !cap_rd, "R7 iu_wr pulse", 64'({cap_wr, cap_rd}), 64'b10);
      check(cap_kind == 2'd2 && cap_port == 2'd1 && cap_wdata == 8'h77, "R7 iu fields",
            64'({cap_kind, cap_port, cap_wdata}), 64'({2'd2, 2'd1, 8'h77}));
      bus_write(4'd7, 8'hC0);
      bus_read(4'd10, 8'hCE, "R8 page3 offset10 read");
      check(cap_rd && !cap_wr, "R8 iu_rd pulse", 64'({cap_wr, cap_rd}), 64'b01);
      bus_write(4'd7, 8'h40);
      bus_read(4'd8, 8'hC4, "R8 page1 offset8 read");

      // R9 page 0
      bus_write(4'd7, 8'h00);
      bus_write(4'd8, 8'h55);
      check(!cap_wr, "R9 no iu_wr on page 0", 64'(cap_wr), 64'h0);
      bus_read(4'd8, 8'h00, "R9 page0 paged read");
      check(!cap_rd, "R9 no iu_rd on page 0", 64'(cap_rd), 64'h0);

      // R10 void offsets
      bus_read(4'd11, 8'h00, "R10 offset11 read");
      bus_read(4'd15, 8'h00, "R10 offset15 read");
      bus_write(4'd12, 8'hFF);
      check(pad_pull == 48'h3C00_0000_0FA5, "R10 void write keeps pulls", 64'(pad_pull), 64'h3C00_0000_0FA5);
      check(!cap_wr, "R10 void write no iu_wr", 64'(cap_wr), 64'h0);
      bus_read(4'd7, 8'h00, "R10 void write keeps control");

      settle(3);
      check(sb_q.size() == 0, "scoreboard drained", 64'(sb_q.size()), 64'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule